// File: doc/BRIEF.md
# Serial On-Screen-Display Command Decoder

This block takes 8-bit words from a three-wire serial port (active-low select, serial clock, serial data) and turns them into writes for an on-screen-display engine. A word with its top bit set names a command and may carry fields of its own. A word with its top bit clear is data for the command most recently named. Decoded commands load the vertical and horizontal start positions, the per-line character sizes and four control registers. They also produce write strobes into a 12-row by 24-column character memory and start a sweep that fills that memory with blank codes.

The serial pins are synchronised into the block clock, so the port may run at any rate well below that clock. Once the character-write command is decoded, every later word in the same select window, whatever its top bit, is a character code. Each code is written at the current address, and the address then advances in row-major order. Raising select ends the window, drops any partial word and returns the decoder to the write-address command.

Top module: `osd_cmd_decoder`

## Requirements
- R1: Serial data is sampled on rising serial-clock edges while `ser_csn` is low, most significant bit first. Eight bits make one word. Bits already shifted in when `ser_csn` goes high are discarded, and clock edges while it is high are ignored. A completed word affects the outputs after the fourth clock edge, counting the clock edge that first samples its eighth serial-clock rise as the first.
- R2: A word with bit 7 = 1 is an identification word and sets the current command to bits 6:4. A word with bit 7 = 0 is data for the current command, and any number of data words may follow one identification word. Position, size and control outputs change only in the cycle after a completed word.
- R3: Command 0 (identification 1000_rrrr) sets the write row to bits 3:0. Its data word sets the write column to bits 4:0.
- R4: Command 1 (identification 1001_00ab) latches the attribute pair {a,b}: bit 0 selects reverse video and bit 1 selects highlight/flash. It locks the decoder. While locked, every word, including those with bit 7 = 1, is written to memory as a character code together with the latched attributes.
- R5: After each character write, the column advances. Column 23 wraps to 0 and advances the row, and row 11 wraps to 0.
- R6: A rising `ser_csn` returns the current command to command 0 and releases the lock.
- R7: Command 2 (1010_ssss) loads the size of display line 1 from bits 1:0 and of line 2 from bits 3:2. Its data word loads `vstart` from bits 5:0.
- R8: Command 3 (1011_ssss) loads the size of line 9 from bits 1:0 and of line 11 from bits 3:2. Its data word loads `hstart` from bits 5:0. `line_size` is packed as {line11, line9, line2, line1}.
- R9: Commands 4 to 7 store their identification bits 3:0 in `ctl_id[4k+3:4k]` and their data bits 6:0 in `ctl_dat[7k+6:7k]`, where k is the command number minus 4.
- R10: `rst_n` low clears every register, sets the command to 0, releases the lock and stops any sweep.
- R11: A command-4 identification word with bit 3 set clears all registers, starts no sweep and causes every word to be ignored until `ser_csn` rises.
- R12: A command-4 identification word with bit 3 clear and bit 2 set starts a sweep. The sweep writes code 0xFF with attributes 0 to all 288 locations in row-major order, one location per clock, and `erase_busy` is high while it runs. A new request restarts the sweep at location 0.
- R13: A character write that falls during a sweep takes the memory port for that cycle, and the sweep holds its position for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_csn | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock, data taken on rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| mem_we | output | 1 | Character memory write strobe |
| mem_row | output | 4 | Write row (0 when idle) |
| mem_col | output | 5 | Write column (0 when idle) |
| mem_code | output | 8 | Character code to write |
| mem_attr | output | 2 | {highlight/flash, reverse video} |
| erase_busy | output | 1 | Memory fill sweep running |
| vstart | output | 6 | Vertical start position, in lines |
| hstart | output | 6 | Horizontal start position, in dot periods |
| line_size | output | 8 | {line11, line9, line2, line1} size codes |
| ctl_id | output | 16 | Identification fields of commands 4 to 7 |
| ctl_dat | output | 28 | Data fields of commands 4 to 7 |

## Verification
The bench targets identification-valued codes inside the locked window. A decoder that still parsed them as commands would change state instead of writing a code. It wraps the address at column 23 of row 11, where a wrong limit would write to column 24 or row 12. It abandons a partial word under select and toggles the serial clock while select is high; a design that kept the stale bits would misalign every later word. It overlaps a character write with a sweep, where a wrong arbiter would drop the code or skip a blank location, and it checks that the register-reset window ignores every word and starts no sweep.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;

  localparam int WORD_W = 8;
  localparam int ATTR_W = 2;
  localparam int POS_W  = 6;
  localparam int NUM_CTL = 4;
  localparam int CTL_ID_W = 4;
  localparam int CTL_DAT_W = 7;

  typedef enum logic [2:0] {
    CMD_ADDR = 3'd0,
    CMD_CHAR = 3'd1,
    CMD_VPOS = 3'd2,
    CMD_HPOS = 3'd3,
    CMD_CTL1 = 3'd4,
    CMD_CTL2 = 3'd5,
    CMD_CTL3 = 3'd6,
    CMD_CTL4 = 3'd7
  } cmd_e;

  // True when an index sits at (or beyond) the last slot of a range of n.
  function automatic logic at_last(input int unsigned v, input int unsigned n);
    return v >= n - 1;
  endfunction

endpackage

// File: rtl/osd_ser_rx.sv
module osd_ser_rx
  import osd_cmd_pkg::*;
#(
  parameter int BYTE_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              word_vld_o,
  output logic [BYTE_W-1:0] word_o,
  output logic              cs_rise_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] PIN_IDLE = 3'b100;

  logic [NPIN-1:0] pins, meta_q, sync_q, prev_q;
  assign pins = {csn_i, sck_i, sdi_i};

  // Two-stage synchroniser plus one history stage, one per pin.
  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= PIN_IDLE[g];
        sync_q[g] <= PIN_IDLE[g];
        prev_q[g] <= PIN_IDLE[g];
      end else begin
        meta_q[g] <= pins[g];
        sync_q[g] <= meta_q[g];
        prev_q[g] <= sync_q[g];
      end
    end
  end

  logic csn_s, sck_rise, cs_up, sdi_s;
  assign csn_s    = sync_q[2];
  assign sck_rise = sync_q[1] & ~prev_q[1];
  assign cs_up    = sync_q[2] & ~prev_q[2];
  assign sdi_s    = sync_q[0];

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shf_q;
  logic [BYTE_W-1:0] shf_next;
  assign shf_next = {shf_q[BYTE_W-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      shf_q      <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
      cs_rise_o  <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      cs_rise_o  <= cs_up;
      if (csn_s) begin
        cnt_q <= '0;
      end else if (sck_rise) begin
        shf_q <= shf_next;
        if (cnt_q == CNT_W'(BYTE_W - 1)) begin
          cnt_q      <= '0;
          word_o     <= shf_next;
          word_vld_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osd_cmd_fsm.sv
module osd_cmd_fsm
  import osd_cmd_pkg::*;
#(
  parameter int N_ROWS = 12,
  parameter int N_COLS = 24,
  parameter int ROW_W  = $clog2(N_ROWS),
  parameter int COL_W  = $clog2(N_COLS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            word_vld,
  input  logic [WORD_W-1:0]               word_in,
  input  logic                            cs_rise,
  output logic                            char_we,
  output logic [ROW_W-1:0]                char_row,
  output logic [COL_W-1:0]                char_col,
  output logic [WORD_W-1:0]               char_code,
  output logic [ATTR_W-1:0]               char_attr,
  output logic                            erase_req,
  output logic                            locked,
  output logic                            hold,
  output logic [POS_W-1:0]                vstart,
  output logic [POS_W-1:0]                hstart,
  output logic [4*ATTR_W-1:0]             line_size,
  output logic [NUM_CTL*CTL_ID_W-1:0]     ctl_id,
  output logic [NUM_CTL*CTL_DAT_W-1:0]    ctl_dat
);
  cmd_e              cmd_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [ATTR_W-1:0] attr_q;

  logic is_id, accept, ctl1_id, regs_clr, decode;
  cmd_e id_cmd;
  assign is_id    = word_in[WORD_W-1];
  assign id_cmd   = cmd_e'(word_in[6:4]);
  assign accept   = word_vld & ~hold;
  assign decode   = accept & ~locked;
  assign ctl1_id  = decode & is_id & (id_cmd == CMD_CTL1);
  assign regs_clr = ctl1_id & word_in[3];
  assign erase_req = ctl1_id & ~word_in[3] & word_in[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= CMD_ADDR;
      locked    <= 1'b0;
      hold      <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      attr_q    <= '0;
      char_we   <= 1'b0;
      char_row  <= '0;
      char_col  <= '0;
      char_code <= '0;
      char_attr <= '0;
      vstart    <= '0;
      hstart    <= '0;
      line_size <= '0;
    end else begin
      char_we <= 1'b0;
      if (cs_rise) begin
        cmd_q  <= CMD_ADDR;
        locked <= 1'b0;
        hold   <= 1'b0;
      end else if (accept && locked) begin
        char_we   <= 1'b1;
        char_row  <= row_q;
        char_col  <= col_q;
        char_code <= word_in;
        char_attr <= attr_q;
        if (at_last(32'(col_q), N_COLS)) begin
          col_q <= '0;
          row_q <= at_last(32'(row_q), N_ROWS) ? '0 : row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end else if (decode && is_id) begin
        cmd_q <= id_cmd;
        if (regs_clr) begin
          hold      <= 1'b1;
          row_q     <= '0;
          col_q     <= '0;
          attr_q    <= '0;
          vstart    <= '0;
          hstart    <= '0;
          line_size <= '0;
        end else begin
          case (id_cmd)
            CMD_ADDR: row_q <= ROW_W'(word_in[3:0]);
            CMD_CHAR: begin
              locked <= 1'b1;
              attr_q <= word_in[ATTR_W-1:0];
            end
            CMD_VPOS: line_size[3:0] <= word_in[3:0];
            CMD_HPOS: line_size[7:4] <= word_in[3:0];
            default: ;
          endcase
        end
      end else if (decode) begin
        case (cmd_q)
          CMD_ADDR: col_q  <= COL_W'(word_in[4:0]);
          CMD_VPOS: vstart <= word_in[POS_W-1:0];
          CMD_HPOS: hstart <= word_in[POS_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // One id/data register pair per control command.
  for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
    localparam cmd_e MY_CMD = cmd_e'(4 + k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_id[k*CTL_ID_W +: CTL_ID_W]    <= '0;
        ctl_dat[k*CTL_DAT_W +: CTL_DAT_W] <= '0;
      end else if (regs_clr) begin
        ctl_id[k*CTL_ID_W +: CTL_ID_W]    <= '0;
        ctl_dat[k*CTL_DAT_W +: CTL_DAT_W] <= '0;
      end else if (decode && is_id && id_cmd == MY_CMD) begin
        ctl_id[k*CTL_ID_W +: CTL_ID_W] <= word_in[CTL_ID_W-1:0];
      end else if (decode && !is_id && cmd_q == MY_CMD) begin
        ctl_dat[k*CTL_DAT_W +: CTL_DAT_W] <= word_in[CTL_DAT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/osd_erase_seq.sv
module osd_erase_seq #(
  parameter int N_ROWS = 12,
  parameter int N_COLS = 24,
  parameter int ROW_W  = $clog2(N_ROWS),
  parameter int COL_W  = $clog2(N_COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stall,
  output logic             busy,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  logic row_end, col_end;
  assign row_end = (row == ROW_W'(N_ROWS - 1));
  assign col_end = (col == COL_W'(N_COLS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      row  <= '0;
      col  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      row  <= '0;
      col  <= '0;
    end else if (busy && !stall) begin
      if (col_end) begin
        col <= '0;
        if (row_end) begin
          busy <= 1'b0;
          row  <= '0;
        end else begin
          row <= row + 1'b1;
        end
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
  import osd_cmd_pkg::*;
#(
  parameter int N_ROWS = 12,
  parameter int N_COLS = 24,
  parameter int ROW_W  = $clog2(N_ROWS),
  parameter int COL_W  = $clog2(N_COLS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_csn,
  input  logic                         ser_clk,
  input  logic                         ser_dat,
  output logic                         mem_we,
  output logic [ROW_W-1:0]             mem_row,
  output logic [COL_W-1:0]             mem_col,
  output logic [WORD_W-1:0]            mem_code,
  output logic [ATTR_W-1:0]            mem_attr,
  output logic                         erase_busy,
  output logic [POS_W-1:0]             vstart,
  output logic [POS_W-1:0]             hstart,
  output logic [4*ATTR_W-1:0]          line_size,
  output logic [NUM_CTL*CTL_ID_W-1:0]  ctl_id,
  output logic [NUM_CTL*CTL_DAT_W-1:0] ctl_dat
);
  localparam logic [WORD_W-1:0] BLANK_CODE = '1;

  // Named internal events, also used by the bound checker.
  logic              word_vld, cs_rise, char_we, erase_req, locked, hold;
  logic [WORD_W-1:0] rx_word;
  logic [ROW_W-1:0]  char_row, er_row;
  logic [COL_W-1:0]  char_col, er_col;
  logic [WORD_W-1:0] char_code;
  logic [ATTR_W-1:0] char_attr;

  osd_ser_rx #(.BYTE_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .csn_i(ser_csn), .sck_i(ser_clk), .sdi_i(ser_dat),
    .word_vld_o(word_vld), .word_o(rx_word), .cs_rise_o(cs_rise)
  );

  osd_cmd_fsm #(.N_ROWS(N_ROWS), .N_COLS(N_COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .word_vld(word_vld), .word_in(rx_word), .cs_rise(cs_rise),
    .char_we(char_we), .char_row(char_row), .char_col(char_col),
    .char_code(char_code), .char_attr(char_attr),
    .erase_req(erase_req), .locked(locked), .hold(hold),
    .vstart(vstart), .hstart(hstart), .line_size(line_size),
    .ctl_id(ctl_id), .ctl_dat(ctl_dat)
  );

  osd_erase_seq #(.N_ROWS(N_ROWS), .N_COLS(N_COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_erase (
    .clk(clk), .rst_n(rst_n),
    .start(erase_req), .stall(char_we),
    .busy(erase_busy), .row(er_row), .col(er_col)
  );

  // Memory port: a character write wins, the sweep uses idle cycles.
  always_comb begin
    mem_we   = char_we | erase_busy;
    mem_row  = '0;
    mem_col  = '0;
    mem_code = '0;
    mem_attr = '0;
    if (char_we) begin
      mem_row  = char_row;
      mem_col  = char_col;
      mem_code = char_code;
      mem_attr = char_attr;
    end else if (erase_busy) begin
      mem_row  = er_row;
      mem_col  = er_col;
      mem_code = BLANK_CODE;
    end
  end
endmodule

// File: rtl/osd_cmd_decoder_chk.sv
module osd_cmd_decoder_chk #(
  parameter int N_ROWS = 12,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             word_vld,
  input logic             cs_rise,
  input logic             char_we,
  input logic             erase_req,
  input logic             locked,
  input logic             hold,
  input logic             erase_busy,
  input logic             mem_we,
  input logic [7:0]       mem_code,
  input logic [1:0]       mem_attr,
  input logic [ROW_W-1:0] er_row,
  input logic [COL_W-1:0] er_col,
  input logic [5:0]       vstart,
  input logic [5:0]       hstart,
  input logic [7:0]       line_size
);
  p_word_cs_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld && cs_rise));

  p_regs_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> ($stable(vstart) && $stable(hstart) && $stable(line_size)));

  p_lock_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !locked);

  p_hold_no_erase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !erase_req);

  p_hold_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> !char_we);

  p_sweep_fill_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && !char_we) |-> (mem_we && mem_code == 8'hFF && mem_attr == 2'b00));

  p_sweep_row_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> (32'(er_row) < N_ROWS));

  p_sweep_pause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && char_we && !erase_req) |=> (er_row == $past(er_row) && er_col == $past(er_col)));
endmodule

bind osd_cmd_decoder osd_cmd_decoder_chk #(.N_ROWS(N_ROWS), .ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .cs_rise(cs_rise),
  .char_we(char_we), .erase_req(erase_req), .locked(locked), .hold(hold),
  .erase_busy(erase_busy), .mem_we(mem_we), .mem_code(mem_code), .mem_attr(mem_attr),
  .er_row(er_row), .er_col(er_col), .vstart(vstart), .hstart(hstart), .line_size(line_size)
);

// File: tb/osd_cmd_decoder_test.sv
module osd_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, sdi = 1'b0;

  logic        mem_we, erase_busy;
  logic [3:0]  mem_row;
  logic [4:0]  mem_col;
  logic [7:0]  mem_code;
  logic [1:0]  mem_attr;
  logic [5:0]  vstart, hstart;
  logic [7:0]  line_size;
  logic [15:0] ctl_id;
  logic [27:0] ctl_dat;

  always #4 clk = ~clk;

  osd_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .ser_csn(csn), .ser_clk(sck), .ser_dat(sdi),
    .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col), .mem_code(mem_code),
    .mem_attr(mem_attr), .erase_busy(erase_busy), .vstart(vstart), .hstart(hstart),
    .line_size(line_size), .ctl_id(ctl_id), .ctl_dat(ctl_dat)
  );

  int total = 0, bad = 0, cyc = 0;
  string phase = "R10";
  bit done = 0;

  // ---------------- behavioural reference model ----------------
  int h1c, h2c, h3c, h1k, h2k, h3k, h1d, h2d, h3d;
  int bitcnt, shreg, pend_cs, pend_word, pend_val;
  int m_cmd, m_lock, m_hold, m_row, m_col, m_attr;
  int m_vs, m_hs, m_sz;
  int m_cid[4], m_cdat[4];
  int m_cwe, m_wr, m_wc, m_wcode, m_wattr;
  int m_busy, m_ptr;

  task automatic model_clear_regs();
    m_row = 0; m_col = 0; m_attr = 0; m_vs = 0; m_hs = 0; m_sz = 0;
    foreach (m_cid[i]) begin m_cid[i] = 0; m_cdat[i] = 0; end
  endtask

  task automatic model_word(input int w);
    int c;
    c = (w >> 4) & 7;
    if (m_hold) return;
    if (m_lock) begin
      m_cwe = 1; m_wr = m_row; m_wc = m_col; m_wcode = w; m_wattr = m_attr;
      m_col = m_col + 1;
      if (m_col >= 24) begin m_col = 0; m_row = m_row + 1; if (m_row >= 12) m_row = 0; end
    end else if (w >= 128) begin
      m_cmd = c;
      if (c == 4 && (w & 8)) begin m_hold = 1; model_clear_regs(); end
      else if (c == 0) m_row = w & 15;
      else if (c == 1) begin m_lock = 1; m_attr = w & 3; end
      else if (c == 2) m_sz = (m_sz & 8'hF0) | (w & 15);
      else if (c == 3) m_sz = (m_sz & 8'h0F) | ((w & 15) << 4);
      else begin
        m_cid[c-4] = w & 15;
        if (c == 4 && (w & 4)) begin m_busy = 1; m_ptr = 0; end
      end
    end else begin
      if (m_cmd == 0) m_col = w & 31;
      else if (m_cmd == 2) m_vs = w & 63;
      else if (m_cmd == 3) m_hs = w & 63;
      else if (m_cmd >= 4) m_cdat[m_cmd-4] = w & 127;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1c = 1; h2c = 1; h3c = 1; h1k = 0; h2k = 0; h3k = 0; h1d = 0; h2d = 0; h3d = 0;
      bitcnt = 0; shreg = 0; pend_cs = 0; pend_word = 0; pend_val = 0;
      m_cmd = 0; m_lock = 0; m_hold = 0; model_clear_regs();
      m_cwe = 0; m_wr = 0; m_wc = 0; m_wcode = 0; m_wattr = 0; m_busy = 0; m_ptr = 0;
    end else begin
      if (m_busy && !m_cwe) begin
        if (m_ptr == 287) begin m_busy = 0; m_ptr = 0; end else m_ptr = m_ptr + 1;
      end
      m_cwe = 0;
      if (pend_cs) begin m_cmd = 0; m_lock = 0; m_hold = 0; end
      if (pend_word) model_word(pend_val);
      pend_cs = 0; pend_word = 0;
      if (h2c) begin
        bitcnt = 0;
        if (!h3c) pend_cs = 1;
      end else if (h2k && !h3k) begin
        shreg = ((shreg << 1) | h2d) & 255;
        bitcnt = bitcnt + 1;
        if (bitcnt == 8) begin pend_word = 1; pend_val = shreg; bitcnt = 0; end
      end
      h3c = h2c; h2c = h1c; h1c = csn;
      h3k = h2k; h2k = h1k; h1k = sck;
      h3d = h2d; h2d = h1d; h1d = sdi;
    end
  end

  function automatic logic [63:0] model_vec();
    logic [63:0] v;
    logic [15:0] cid;
    logic [27:0] cdat;
    int r, c, code, at, we;
    we = m_cwe | m_busy; r = 0; c = 0; code = 0; at = 0;
    if (m_cwe) begin r = m_wr; c = m_wc; code = m_wcode; at = m_wattr; end
    else if (m_busy) begin r = m_ptr / 24; c = m_ptr % 24; code = 255; end
    for (int i = 0; i < 4; i++) begin
      cid[i*4 +: 4]  = 4'(m_cid[i]);
      cdat[i*7 +: 7] = 7'(m_cdat[i]);
    end
    v = {1'(we), 4'(r), 5'(c), 8'(code), 2'(at), 1'(m_busy), 6'(m_vs), 6'(m_hs), 8'(m_sz), 23'(0)};
    return v ^ {20'd0, cid, cdat};
  endfunction

  function automatic logic [63:0] dut_vec();
    return {mem_we, mem_row, mem_col, mem_code, mem_attr, erase_busy, vstart, hstart, line_size, 23'd0}
           ^ {20'd0, ctl_id, ctl_dat};
  endfunction

  // ---------------- checks ----------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) chk({phase, " per-cycle"}, dut_vec(), model_vec());
  end

  // Character writes (not blank sweep cycles) and sweep fill count.
  logic [18:0] wq[$];
  int fill_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (erase_busy && mem_code == 8'hFF && mem_attr == 2'b00) fill_cnt++;
      else wq.push_back({mem_row, mem_col, mem_code, mem_attr});
    end
  end

  task automatic chk_write(input string req, input logic [3:0] r, input logic [4:0] c,
                           input logic [7:0] code, input logic [1:0] at);
    logic [18:0] got;
    got = (wq.size() > 0) ? wq.pop_front() : 19'h7FFFF;
    chk(req, 64'(got), 64'({r, c, code, at}));
  endtask

  // ---------------- stimulus ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] w, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); sdi = w[i];
      wait_clk(3); sck = 1'b1;
      wait_clk(3); sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] w);
    send_bits(w, 8);
  endtask

  task automatic sel_on();
    @(negedge clk); csn = 1'b0; wait_clk(4);
  endtask

  task automatic sel_off();
    wait_clk(6); csn = 1'b1; wait_clk(8);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    phase = "R10";
    chk("R10 reset state", dut_vec(), 64'd0);

    phase = "R7";
    sel_on(); send(8'hA6); send(8'h2A); sel_off();
    chk("R7 vstart", 64'(vstart), 64'h2A);
    chk("R7 line1/line2 size", 64'(line_size[3:0]), 64'h6);

    phase = "R2";
    sel_on(); send(8'hA0); send(8'h05); send(8'h11); sel_off();
    chk("R2 repeated data words", 64'(vstart), 64'h11);

    phase = "R8";
    sel_on(); send(8'hBD); send(8'h3F); sel_off();
    chk("R8 hstart", 64'(hstart), 64'h3F);
    chk("R8 packed sizes", 64'(line_size), 64'hD0);

    phase = "R4";
    wq.delete();
    sel_on(); send(8'h85); send(8'h16); send(8'h93);
    send(8'h41); send(8'h92); send(8'h07); sel_off();
    chk_write("R3 R4 first write at row5 col22", 4'd5, 5'd22, 8'h41, 2'd3);
    chk_write("R4 id-valued code written", 4'd5, 5'd23, 8'h92, 2'd3);
    chk_write("R5 column wrap to next row", 4'd6, 5'd0, 8'h07, 2'd3);

    phase = "R6";
    sel_on(); send(8'h03); send(8'h90); send(8'h55); sel_off();
    chk_write("R6 select release returns to address command", 4'd6, 5'd3, 8'h55, 2'd0);

    phase = "R5";
    sel_on(); send(8'h8B); send(8'h17); send(8'h91); send(8'h01); send(8'h02); sel_off();
    chk_write("R5 last location", 4'd11, 5'd23, 8'h01, 2'd1);
    chk_write("R5 row wrap to origin", 4'd0, 5'd0, 8'h02, 2'd1);
    chk("R4 no stray writes", 64'(wq.size()), 64'd0);

    phase = "R1";
    sel_on(); send_bits(8'hFF, 5); sel_off();
    send(8'hA0); send(8'h3C);
    wait_clk(8);
    chk("R1 clocking while deselected ignored", 64'(vstart), 64'h11);
    sel_on(); send(8'hA0); send(8'h15); sel_off();
    chk("R1 partial word discarded", 64'(vstart), 64'h15);

    phase = "R9";
    sel_on(); send(8'hC1); send(8'h7F); send(8'hD9); send(8'h12);
    send(8'hEA); send(8'h33); send(8'hF6); send(8'h44); sel_off();
    chk("R9 control ids", 64'(ctl_id), 64'h6A91);
    chk("R9 control data", 64'(ctl_dat), 64'({7'h44, 7'h33, 7'h12, 7'h7F}));

    phase = "R12";
    wq.delete(); fill_cnt = 0;
    sel_on(); send(8'hC4);
    wait_clk(3);
    chk("R12 sweep busy", 64'(erase_busy), 64'd1);
    phase = "R13";
    send(8'h91); send(8'h33); sel_off();
    wait_clk(300);
    chk("R12 sweep covers every location", 64'(fill_cnt), 64'd288);
    chk("R12 sweep ends", 64'(erase_busy), 64'd0);
    chk("R13 write during sweep kept", 64'(wq.size() == 1 ? wq[0][9:0] : 10'h3FF), 64'({8'h33, 2'd1}));

    phase = "R11";
    sel_on(); send(8'hCC); send(8'hA0); send(8'h11);
    wait_clk(4);
    chk("R11 registers cleared", 64'({vstart, hstart, line_size, ctl_id}), 64'd0);
    chk("R11 no sweep", 64'(erase_busy), 64'd0);
    sel_off();
    sel_on(); send(8'hA0); send(8'h11); sel_off();
    chk("R11 released by select", 64'(vstart), 64'h11);

    phase = "R10";
    sel_on(); send(8'hC4);
    wait_clk(10);
    @(negedge clk); rst_n = 1'b0;
    wait_clk(2);
    chk("R10 mid-run reset", dut_vec(), 64'd0);
    csn = 1'b1;
    wait_clk(2); rst_n = 1'b1;
    wait_clk(10);
    chk("R10 quiet after reset", 64'({mem_we, erase_busy}), 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule